// File: doc/BRIEF.md
# ADC Sample Window Monitor

This block sits beside a multiplexed 10-bit converter and checks every converted sample against a set of programmable windows. No processor is involved. Each sample arrives with a one-cycle valid strobe and a channel tag. The tag covers four external inputs and six internal supply monitors, 0 to 9.

The block holds a number of independent watch slots. The default is four. Each slot has the following settings:

- a channel selector
- a lower bound and an upper bound
- a monitor enable
- an interrupt enable

A sample is checked by a slot when the slot is enabled and the sample's tag equals the slot's channel. A sample below the slot's lower bound latches a sticky "under" flag. A sample above the slot's upper bound latches a sticky "over" flag.

The alert output is the OR of the flags of every slot whose interrupt enable is set. It serves both as an interrupt and as a wake request while the processor sleeps.

A small register port sets up the slots, reads them back, reads the flags and clears flags by writing 1.

A two-state controller sequences the samples:

- `ST_IDLE` means no sample is held. The transition *capture* (strobe high) moves it to `ST_EVAL`.
- In `ST_EVAL` the held sample is compared on the next edge. The transition *chain* (a new strobe) stays in `ST_EVAL` and holds the new sample at the same time. The transition *drain* (no strobe) returns to `ST_IDLE`.

Top module: `adc_window_watch`

## Requirements
- R1: Reset has the following effect. Every slot setting reads back as zero. Both flag groups are clear. `alert_irq` is low. The controller is in `ST_IDLE`.
- R2: A sample strobed on clock edge k is compared on edge k+1. Any flag it sets is visible after edge k+1. No flag is set while no sample is held.
- R3: A slot checks a sample only when the slot's monitor enable (control bit 8) is 1 and the sample's channel tag equals the slot's channel field (control bits 3:0). Otherwise the slot's flags are unaffected.
- R4: The window is inclusive. A sample strictly below the lower bound sets the slot's under flag. A sample strictly above the upper bound sets the slot's over flag. A sample equal to either bound sets neither flag.
- R5: Flags are sticky. Once set, a flag stays set until it is cleared through the register port, and a flag never rises without a comparison event.
- R6: The status register is at address 4·NUM_PAIRS (16 by default). It reads under flags in bits [NUM_PAIRS-1:0] and over flags in bits [2·NUM_PAIRS-1:NUM_PAIRS]. Writing it clears every flag whose bit is 1. Bits written as 0 have no effect.
- R7: A flag set by a comparison and cleared by a status write in the same cycle ends up set.
- R8: `alert_irq` is high exactly when some slot whose interrupt enable (control bit 9) is 1 has its under or over flag set. It follows enable changes and clears without waiting for a sample.
- R9: Slot n occupies addresses 4n to 4n+3:
  - 4n is control: bits 3:0 channel, bit 8 monitor enable, bit 9 interrupt enable.
  - 4n+1 is the lower bound, bits 9:0.
  - 4n+2 is the upper bound, bits 9:0.
  - 4n+3 reads zero.
  - Written values read back; other bits read zero.
- R10: Several slots may watch the same channel. One sample is checked by all matching slots at once, each against its own window.
- R11: Samples strobed on consecutive cycles are each compared, none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a converted sample |
| smp_data | input | SAMPLE_W (10) | Converted sample value |
| smp_chan | input | CHAN_W (4) | Channel tag of the sample |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W (5) | Write address |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_raddr | input | ADDR_W (5) | Read address |
| reg_rdata | output | DATA_W (32) | Combinational read data |
| alert_irq | output | 1 | Interrupt / wake request |

## Verification
The assertions check the following on every cycle:

- A strobe always leaves the controller in `ST_EVAL`.
- Comparison events occur only in `ST_EVAL`.
- A set flag stays set and no flag appears without an event.
- A written-1 clear takes effect.
- A set wins against a clear in the same cycle.

Only the bench's scenarios can show the rest:

- the inclusive bounds and the channel matching and enable gating;
- several slots on one channel;
- back-to-back samples;
- the alert's gating by the interrupt enables.

The bench shows these by comparing status and alert against a model of the slots across directed and random traffic.

// File: rtl/adcw_pkg.sv
package adcw_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EVAL = 1'b1
    } mon_state_e;

    typedef enum logic [1:0] {
        FLD_CTRL = 2'd0,
        FLD_LOW  = 2'd1,
        FLD_HIGH = 2'd2,
        FLD_RSVD = 2'd3
    } slot_field_e;

    localparam int CTRL_MON_BIT = 8;
    localparam int CTRL_IRQ_BIT = 9;

endpackage

// File: rtl/adcw_regs.sv
module adcw_regs #(
    parameter int NUM_PAIRS = 4,
    parameter int SAMPLE_W  = 10,
    parameter int CHAN_W    = 4,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    waddr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [ADDR_W-1:0]    raddr,
    input  logic [NUM_PAIRS-1:0] flag_lo,
    input  logic [NUM_PAIRS-1:0] flag_hi,
    output logic [DATA_W-1:0]    rdata,
    output logic [CHAN_W-1:0]    cfg_chan [NUM_PAIRS],
    output logic [NUM_PAIRS-1:0] cfg_mon,
    output logic [NUM_PAIRS-1:0] cfg_irq,
    output logic [SAMPLE_W-1:0]  cfg_lo   [NUM_PAIRS],
    output logic [SAMPLE_W-1:0]  cfg_hi   [NUM_PAIRS],
    output logic [NUM_PAIRS-1:0] clr_lo,
    output logic [NUM_PAIRS-1:0] clr_hi
);
    import adcw_pkg::*;

    localparam int PIDX_W      = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
    localparam int STATUS_ADDR = 4 * NUM_PAIRS;

    logic                w_in_slot;
    logic [PIDX_W-1:0]   w_pair;
    slot_field_e         w_fld;
    logic                r_in_slot;
    logic [PIDX_W-1:0]   r_pair;
    slot_field_e         r_fld;
    logic                w_status;

    assign w_in_slot = (waddr < ADDR_W'(STATUS_ADDR));
    assign w_pair    = waddr[PIDX_W+1:2];
    assign w_fld     = slot_field_e'(waddr[1:0]);
    assign r_in_slot = (raddr < ADDR_W'(STATUS_ADDR));
    assign r_pair    = raddr[PIDX_W+1:2];
    assign r_fld     = slot_field_e'(raddr[1:0]);
    assign w_status  = wr && (waddr == ADDR_W'(STATUS_ADDR));

    assign clr_lo = w_status ? wdata[NUM_PAIRS-1:0]           : '0;
    assign clr_hi = w_status ? wdata[2*NUM_PAIRS-1:NUM_PAIRS] : '0;

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_slot
        logic hit;
        assign hit = wr && w_in_slot && (w_pair == PIDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_chan[i] <= '0;
                cfg_mon[i]  <= 1'b0;
                cfg_irq[i]  <= 1'b0;
                cfg_lo[i]   <= '0;
                cfg_hi[i]   <= '0;
            end else if (hit) begin
                unique case (w_fld)
                    FLD_CTRL: begin
                        cfg_chan[i] <= wdata[CHAN_W-1:0];
                        cfg_mon[i]  <= wdata[CTRL_MON_BIT];
                        cfg_irq[i]  <= wdata[CTRL_IRQ_BIT];
                    end
                    FLD_LOW:  cfg_lo[i] <= wdata[SAMPLE_W-1:0];
                    FLD_HIGH: cfg_hi[i] <= wdata[SAMPLE_W-1:0];
                    FLD_RSVD: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (raddr == ADDR_W'(STATUS_ADDR)) begin
            rdata[NUM_PAIRS-1:0]           = flag_lo;
            rdata[2*NUM_PAIRS-1:NUM_PAIRS] = flag_hi;
        end else if (r_in_slot) begin
            unique case (r_fld)
                FLD_CTRL: begin
                    rdata[CHAN_W-1:0]   = cfg_chan[r_pair];
                    rdata[CTRL_MON_BIT] = cfg_mon[r_pair];
                    rdata[CTRL_IRQ_BIT] = cfg_irq[r_pair];
                end
                FLD_LOW:  rdata[SAMPLE_W-1:0] = cfg_lo[r_pair];
                FLD_HIGH: rdata[SAMPLE_W-1:0] = cfg_hi[r_pair];
                FLD_RSVD: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/adcw_compare.sv
module adcw_compare #(
    parameter int NUM_PAIRS = 4,
    parameter int SAMPLE_W  = 10,
    parameter int CHAN_W    = 4
) (
    input  logic                 eval,
    input  logic [SAMPLE_W-1:0]  cur_data,
    input  logic [CHAN_W-1:0]    cur_chan,
    input  logic [CHAN_W-1:0]    cfg_chan [NUM_PAIRS],
    input  logic [NUM_PAIRS-1:0] cfg_mon,
    input  logic [SAMPLE_W-1:0]  cfg_lo   [NUM_PAIRS],
    input  logic [SAMPLE_W-1:0]  cfg_hi   [NUM_PAIRS],
    output logic [NUM_PAIRS-1:0] set_lo,
    output logic [NUM_PAIRS-1:0] set_hi
);
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_cmp
        logic watch;
        assign watch     = eval && cfg_mon[i] && (cur_chan == cfg_chan[i]);
        assign set_lo[i] = watch && (cur_data < cfg_lo[i]);
        assign set_hi[i] = watch && (cur_data > cfg_hi[i]);
    end
endmodule

// File: rtl/adcw_flags.sv
module adcw_flags #(
    parameter int NUM_PAIRS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PAIRS-1:0] set_lo,
    input  logic [NUM_PAIRS-1:0] set_hi,
    input  logic [NUM_PAIRS-1:0] clr_lo,
    input  logic [NUM_PAIRS-1:0] clr_hi,
    input  logic [NUM_PAIRS-1:0] irq_en,
    output logic [NUM_PAIRS-1:0] flag_lo,
    output logic [NUM_PAIRS-1:0] flag_hi,
    output logic                 irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_lo <= '0;
            flag_hi <= '0;
        end else begin
            flag_lo <= (flag_lo & ~clr_lo) | set_lo;
            flag_hi <= (flag_hi & ~clr_hi) | set_hi;
        end
    end

    assign irq = |((flag_lo | flag_hi) & irq_en);

    assert_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_lo & ~clr_lo) != '0) |=> ((flag_lo & $past(flag_lo & ~clr_lo)) == $past(flag_lo & ~clr_lo)));

    assert_no_spurious_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_lo & ~$past(flag_lo) & ~$past(set_lo)) == '0) &&
        ((flag_hi & ~$past(flag_hi) & ~$past(set_hi)) == '0));

    assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_hi & ~set_hi) != '0) |=> ((flag_hi & $past(clr_hi & ~set_hi)) == '0));

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_lo & clr_lo) != '0) |=> ((flag_lo & $past(set_lo & clr_lo)) == $past(set_lo & clr_lo)));

endmodule

// File: rtl/adc_window_watch.sv
module adc_window_watch #(
    parameter int NUM_PAIRS = 4,
    parameter int SAMPLE_W  = 10,
    parameter int CHAN_W    = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = ((NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1) + 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [CHAN_W-1:0]   smp_chan,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_waddr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic [ADDR_W-1:0]   reg_raddr,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                alert_irq
);
    import adcw_pkg::*;

    mon_state_e            state, state_nx;
    logic [SAMPLE_W-1:0]   held_data;
    logic [CHAN_W-1:0]     held_chan;
    logic                  eval;

    logic [CHAN_W-1:0]     cfg_chan [NUM_PAIRS];
    logic [SAMPLE_W-1:0]   cfg_lo   [NUM_PAIRS];
    logic [SAMPLE_W-1:0]   cfg_hi   [NUM_PAIRS];
    logic [NUM_PAIRS-1:0]  cfg_mon, cfg_irq;
    logic [NUM_PAIRS-1:0]  set_lo, set_hi, clr_lo, clr_hi, flag_lo, flag_hi;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (smp_valid) state_nx = ST_EVAL;          // capture
            ST_EVAL: state_nx = smp_valid ? ST_EVAL : ST_IDLE;   // chain / drain
        endcase
    end

    // held sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_data <= '0;
            held_chan <= '0;
        end else if (smp_valid) begin
            held_data <= smp_data;
            held_chan <= smp_chan;
        end
    end

    // outputs of the controller
    always_comb begin
        eval = 1'b0;
        unique case (state)
            ST_IDLE: eval = 1'b0;
            ST_EVAL: eval = 1'b1;
        endcase
    end

    adcw_regs #(
        .NUM_PAIRS(NUM_PAIRS), .SAMPLE_W(SAMPLE_W), .CHAN_W(CHAN_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .waddr(reg_waddr),
        .wdata(reg_wdata), .raddr(reg_raddr), .flag_lo(flag_lo),
        .flag_hi(flag_hi), .rdata(reg_rdata), .cfg_chan(cfg_chan),
        .cfg_mon(cfg_mon), .cfg_irq(cfg_irq), .cfg_lo(cfg_lo),
        .cfg_hi(cfg_hi), .clr_lo(clr_lo), .clr_hi(clr_hi)
    );

    adcw_compare #(
        .NUM_PAIRS(NUM_PAIRS), .SAMPLE_W(SAMPLE_W), .CHAN_W(CHAN_W)
    ) u_cmp (
        .eval(eval), .cur_data(held_data), .cur_chan(held_chan),
        .cfg_chan(cfg_chan), .cfg_mon(cfg_mon), .cfg_lo(cfg_lo),
        .cfg_hi(cfg_hi), .set_lo(set_lo), .set_hi(set_hi)
    );

    adcw_flags #(.NUM_PAIRS(NUM_PAIRS)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_lo(set_lo), .set_hi(set_hi),
        .clr_lo(clr_lo), .clr_hi(clr_hi), .irq_en(cfg_irq),
        .flag_lo(flag_lo), .flag_hi(flag_hi), .irq(alert_irq)
    );

    assert_strobe_to_eval_R11: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (state == ST_EVAL));

    assert_set_only_in_eval_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_lo | set_hi) != '0) |-> (state == ST_EVAL));

    assert_idle_after_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid) |=> (state == ST_IDLE));

endmodule

// File: tb/sim_adc_window_watch.sv
module sim_adc_window_watch;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int STATUS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [9:0]  smp_data = '0;
    logic [3:0]  smp_chan = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [4:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        alert_irq;

    int n_chk = 0;
    int n_bad = 0;

    int m_chan [NP];
    int m_mon  [NP];
    int m_ie   [NP];
    int m_lo   [NP];
    int m_hi   [NP];
    logic [NP-1:0] e_lo = '0, e_hi = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_window_watch u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .smp_chan(smp_chan), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .alert_irq(alert_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int i = 0; i < NP; i++)
            if (m_ie[i] != 0 && (e_lo[i] || e_hi[i])) r = 1'b1;
        return r;
    endfunction

    function automatic logic [31:0] exp_ctrl(input int i);
        logic [31:0] v = '0;
        v[3:0] = 4'(m_chan[i]);
        v[8]   = (m_mon[i] != 0);
        v[9]   = (m_ie[i] != 0);
        return v;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_waddr = 5'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_raddr = 5'(a);
        #1 d = reg_rdata;
    endtask

    task automatic cfg(input int i, input int ch, input int mon, input int ie,
                       input int lo, input int hi);
        m_chan[i] = ch; m_mon[i] = mon; m_ie[i] = ie; m_lo[i] = lo; m_hi[i] = hi;
        wr(4*i,   exp_ctrl(i));
        wr(4*i+1, 32'(lo));
        wr(4*i+2, 32'(hi));
    endtask

    task automatic model_sample(input int ch, input int v);
        for (int i = 0; i < NP; i++)
            if (m_mon[i] != 0 && m_chan[i] == ch) begin
                if (v < m_lo[i]) e_lo[i] = 1'b1;
                if (v > m_hi[i]) e_hi[i] = 1'b1;
            end
    endtask

    task automatic send(input int ch, input int v);
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = 4'(ch); smp_data = 10'(v);
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        model_sample(ch, v);
    endtask

    task automatic clear(input logic [31:0] m);
        wr(STATUS, m);
        e_lo = e_lo & ~m[NP-1:0];
        e_hi = e_hi & ~m[2*NP-1:NP];
    endtask

    task automatic verify(input string req);
        logic [31:0] s;
        rd(STATUS, s);
        chk({req, " status"}, s, 32'({e_hi, e_lo}));
        chk({req, " alert"}, 32'(alert_irq), 32'(exp_irq()));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd2718));
        for (int i = 0; i < NP; i++) begin
            m_chan[i] = 0; m_mon[i] = 0; m_ie[i] = 0; m_lo[i] = 0; m_hi[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4*NP; a++) begin
            rd(a, d);
            chk("R1 cfg zero", d, 32'h0);
        end
        verify("R1");
        rst_n = 1'b1;
        @(negedge clk);

        // R9 readback
        cfg(2, 5, 1, 1, 100, 900);
        rd(8, d);  chk("R9 ctrl", d, 32'h305);
        rd(9, d);  chk("R9 low", d, 32'd100);
        rd(10, d); chk("R9 high", d, 32'd900);
        rd(11, d); chk("R9 rsvd", d, 32'h0);
        wr(11, 32'hFFFF_FFFF);
        rd(11, d); chk("R9 rsvd after write", d, 32'h0);
        cfg(2, 0, 0, 0, 0, 0);

        // R4 inclusive bounds
        cfg(0, 1, 1, 1, 200, 300);
        send(1, 200); verify("R4 equal low");
        send(1, 300); verify("R4 equal high");
        send(1, 250); verify("R4 inside");
        send(1, 199); verify("R4 below");
        send(1, 301); verify("R4 above");

        // R3 channel and enable gating
        clear(32'hFF);
        cfg(1, 2, 0, 1, 500, 600);
        send(2, 0);   verify("R3 disabled slot");
        send(3, 0);   verify("R3 other channel");
        send(9, 1023); verify("R3 unwatched channel");

        // R2 latency: flag visible after second edge, not after first
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = 4'd1; smp_data = 10'd5;
        @(negedge clk);
        smp_valid = 1'b0;
        verify("R2 before compare");
        @(negedge clk);
        model_sample(1, 5);
        verify("R2 after compare");

        // R5 sticky over further in-range samples
        send(1, 250); verify("R5 sticky");
        repeat (5) @(negedge clk);
        verify("R5 sticky idle");

        // R6 write-zero no effect, write-one clears
        clear(32'h0);  verify("R6 zero write");
        clear(32'h01); verify("R6 clear one");

        // R8 irq enable gating
        cfg(3, 4, 1, 0, 10, 20);
        send(4, 30); verify("R8 irq masked");
        cfg(3, 4, 1, 1, 10, 20); verify("R8 irq unmasked");
        clear(32'hFF); verify("R8 irq drops on clear");

        // R10 two slots one channel
        cfg(0, 7, 1, 1, 100, 200);
        cfg(1, 7, 1, 1, 150, 400);
        send(7, 120); verify("R10 shared channel low");
        send(7, 300); verify("R10 shared channel high");
        clear(32'hFF);

        // R11 back-to-back
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = 4'd7; smp_data = 10'd50;
        @(negedge clk);
        smp_chan = 4'd7; smp_data = 10'd500;
        @(negedge clk);
        smp_valid = 1'b0;
        @(negedge clk);
        model_sample(7, 50); model_sample(7, 500);
        verify("R11 back-to-back");

        // R7 set wins over same-cycle clear
        @(negedge clk);
        smp_valid = 1'b1; smp_chan = 4'd7; smp_data = 10'd10;
        @(negedge clk);
        smp_valid = 1'b0;
        reg_wr = 1'b1; reg_waddr = 5'(STATUS); reg_wdata = 32'h33;
        @(negedge clk);
        reg_wr = 1'b0;
        e_hi = e_hi & ~4'b0011;
        model_sample(7, 10);
        verify("R7 set wins");

        // random traffic
        clear(32'hFF);
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 10);
            if (op < 2) begin
                cfg(int'($urandom % NP), int'($urandom % 12), int'($urandom % 4 != 0),
                    int'($urandom % 2), int'($urandom % 1024), int'($urandom % 1024));
            end else if (op == 2) begin
                clear($urandom & 32'hFF);
            end else begin
                send(int'($urandom % 12), int'($urandom % 1024));
            end
            verify("R3 R4 R5 R6 R8 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule